// File: doc/BRIEF.md
# Dual-Buffered Mailbox Register

This block is a single data register shared by two agents: a writer (for example a host port) and a reader (for example a CPU port), which may access it in the same cycle. It holds the value in two stages. The capture stage takes every write. The presentation stage drives the read data. A sticky pending flag tells the reader that fresh data is waiting, and this flag, gated by an enable input, forms the interrupt.

A read is an access window: `rd_en` stays high for one or more cycles, and the window closes on the first cycle in which `rd_en` is low. While the window is open, the presentation stage is frozen, so the reader sees one coherent value. A write that lands inside the window goes only to the capture stage. The held value is copied forward when the window closes, and the read then leaves the pending flag set, because the data it returned is already stale. A read with no colliding write clears the flag when its window closes. Address decoding and clock-domain synchronisation sit outside the block; both strobes arrive already synchronous to `clk`.

Top module: `mbox_reg`

## Requirements
- R1: After reset, `rd_data` is 0, `pending` is 0 and `irq` is 0.
- R2: A write while `rd_en` is low loads `wr_data` into both stages. In the following cycle `rd_data` equals that value and `pending` is 1.
- R3: While `rd_en` is high, `rd_data` does not change in the next cycle, whatever writes occur.
- R4: A write made while `rd_en` is high appears on `rd_data` in the cycle after the first cycle in which `rd_en` is low again.
- R5: If several writes occur inside one read window, the last of them is the value presented after the window closes.
- R6: A read window that contains no write clears `pending` in the cycle after it closes, unless a write arrives in the closing cycle.
- R7: A read window that contains at least one write, including a write in its first cycle, leaves `pending` at 1 after it closes.
- R8: A write in the cycle in which `rd_en` falls counts as a write with no read in progress. It is presented directly, and `pending` is 1 afterwards.
- R9: `irq` is 1 exactly when `pending` is 1 and `irq_en` is 1. It is combinational in `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | WIDTH (8) | Write data |
| rd_en | input | 1 | Read window, high for the whole read access |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | WIDTH (8) | Presentation-stage value |
| pending | output | 1 | New-data flag |
| irq | output | 1 | Pending flag gated by the enable |

## Verification
The bench first drives plain writes and reads with no overlap. This shows that the basic path works before any collision is tried. It then drives a multi-cycle read with two writes inside, a write in the first cycle of a read, and a write in the cycle the read ends. These cases separate the held-then-released path (R4, R5, R7) from the direct path (R8), and they show whether a read is wrongly allowed to clear the flag. Masking `irq_en` shows that the interrupt is only a gate on the flag. A long stretch of random strobes, compared cycle by cycle against a behavioural model, covers orderings the directed cases do not reach.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // State of the read-window tracker
    typedef struct packed {
        logic rd_q;    // read window was open last cycle
        logic hold_q;  // a write landed inside the open window
    } win_state_t;

    // State of the pending-flag logic
    typedef struct packed {
        logic pend_q;
    } pend_state_t;

endpackage

// File: rtl/mbox_window_track.sv
module mbox_window_track
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic wr_en,
    output logic rd_done,
    output logic held
);

    win_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.rd_q = rd_en;
        if (rd_en) begin
            s_d.hold_q = s_q.hold_q | wr_en;
        end else begin
            s_d.hold_q = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_done = s_q.rd_q & ~rd_en;
    assign held    = s_q.hold_q;

    // A held write can only exist while a read window was open (R4)
    assert_hold_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> s_q.rd_q);

endmodule

// File: rtl/mbox_stage_regs.sv
module mbox_stage_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_done,
    input  logic             held,
    output logic [WIDTH-1:0] slave_val
);

    typedef struct packed {
        logic [WIDTH-1:0] master_q;
        logic [WIDTH-1:0] slave_q;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.master_q = wr_data;
        end
        if (wr_en && !rd_en) begin
            s_d.slave_q = wr_data;
        end else if (rd_done && held) begin
            s_d.slave_q = s_q.master_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slave_val = s_q.slave_q;

    assert_slave_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(s_q.slave_q));

    assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> (s_q.slave_q == $past(wr_data)));

    assert_last_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.master_q == $past(wr_data)));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && held && !wr_en) |=> (s_q.slave_q == $past(s_q.master_q)));

endmodule

// File: rtl/mbox_pending.sv
module mbox_pending
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rd_done,
    input  logic held,
    input  logic irq_en,
    output logic pend,
    output logic irq
);

    pend_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.pend_q = 1'b1;
        end else if (rd_done && !held) begin
            s_d.pend_q = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend_q;
    assign irq  = s_q.pend_q & irq_en;

    assert_write_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.pend_q);

    assert_clean_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !held && !wr_en) |=> !s_q.pend_q);

    assert_collided_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && held) |=> s_q.pend_q);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: rtl/mbox_reg.sv
module mbox_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             irq_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             pending,
    output logic             irq
);

    logic rd_done;
    logic held;

    mbox_window_track u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rd_done (rd_done),
        .held    (held)
    );

    mbox_stage_regs #(.WIDTH(WIDTH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_done   (rd_done),
        .held      (held),
        .slave_val (rd_data)
    );

    mbox_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_done (rd_done),
        .held    (held),
        .irq_en  (irq_en),
        .pend    (pending),
        .irq     (irq)
    );

    // A direct write in the closing cycle must reach the output (R8)
    assert_close_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && wr_en) |=> (pending && rd_data == $past(wr_data)));

endmodule

// File: tb/sim_mbox_reg.sv
module sim_mbox_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         irq_en = 1'b1;
    logic [W-1:0] rd_data;
    logic         pending;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;

    // Behavioural reference
    int m_cap, m_out, m_pend, m_open, m_collide;

    always #5 clk = ~clk;

    mbox_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .irq_en(irq_en), .rd_data(rd_data),
        .pending(pending), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cap = 0; m_out = 0; m_pend = 0; m_open = 0; m_collide = 0;
        end else begin
            if (m_open != 0 && !rd_en && !wr_en) begin
                if (m_collide != 0) m_out = m_cap;
                else m_pend = 0;
            end
            if (wr_en) begin
                m_cap  = int'(wr_data);
                m_pend = 1;
                if (!rd_en) m_out = int'(wr_data);
            end
            m_collide = rd_en ? ((m_collide != 0 || wr_en) ? 1 : 0) : 0;
            m_open    = rd_en ? 1 : 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R2 R3 R4 R6 R7 model rd_data", int'(rd_data), m_out);
        check("R6 R7 model pending", int'(pending), m_pend);
        check("R9 model irq", int'(irq), (m_pend != 0 && irq_en) ? 1 : 0);
    endtask

    task automatic cyc(input logic w, input logic [W-1:0] d, input logic r);
        @(negedge clk);
        compare_model();
        wr_en = w; wr_data = d; rd_en = r;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 pending", int'(pending), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;

        // R2: plain write
        cyc(1, 8'hA5, 0); cyc(0, 0, 0);
        check("R2 rd_data", int'(rd_data), 'hA5);
        check("R2 pending", int'(pending), 1);
        check("R9 irq on", int'(irq), 1);

        // R6: clean read
        cyc(0, 0, 1); cyc(0, 0, 1);
        check("R3 open read", int'(pending), 1);
        cyc(0, 0, 0); cyc(0, 0, 0);
        check("R6 cleared", int'(pending), 0);
        check("R9 irq off", int'(irq), 0);

        // R3 R4 R5 R7: two writes inside one read
        cyc(0, 0, 1); cyc(1, 8'h3C, 1); cyc(0, 0, 1);
        check("R3 frozen", int'(rd_data), 'hA5);
        cyc(1, 8'h7E, 1); cyc(0, 0, 0);
        check("R3 frozen late", int'(rd_data), 'hA5);
        cyc(0, 0, 0);
        check("R5 last wins", int'(rd_data), 'h7E);
        check("R4 released", int'(rd_data) != 'hA5 ? 1 : 0, 1);
        check("R7 kept", int'(pending), 1);

        // R9: mask
        irq_en = 1'b0; #1;
        check("R9 masked", int'(irq), 0);
        check("R9 pending unaffected", int'(pending), 1);
        irq_en = 1'b1;

        // R8: write in closing cycle
        cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
        check("R6 cleared again", int'(pending), 0);
        cyc(0, 0, 1); cyc(1, 8'h11, 0); cyc(0, 0, 0);
        check("R8 rd_data", int'(rd_data), 'h11);
        check("R8 pending", int'(pending), 1);

        // R7: write in first read cycle
        cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
        cyc(1, 8'h22, 1); cyc(0, 0, 1);
        check("R3 first-cycle write held", int'(rd_data), 'h11);
        cyc(0, 0, 0); cyc(0, 0, 0);
        check("R4 first-cycle release", int'(rd_data), 'h22);
        check("R7 first-cycle keep", int'(pending), 1);

        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            cyc(($urandom % 3) == 0, W'($urandom), ($urandom % 4) != 0 ? rd_en ^ (($urandom % 3) == 0) : 1'b0);
            if ((i % 97) == 0) irq_en = ~irq_en;
        end
        cyc(0, 0, 0); cyc(0, 0, 0);
        finish_run();
    end

endmodule